// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent virtual-to-physical page translations and answers lookups against all of them at once. Each slot keeps a valid flag, a dirty flag, a 20-bit virtual page tag and a 12-bit physical page number. A lookup presents a virtual page and a 12-bit page offset. One cycle later the block reports whether a valid slot matched. On a match it also returns the 24-bit physical address and the slot's dirty flag.

Software or a page-table walker outside the block loads translations through a fill port. A write lookup that hits marks its slot dirty. A flush input drops every translation in one cycle. When a fill needs a slot, the block reuses a slot that already holds the same tag. Failing that, it takes the lowest-numbered empty slot, and failing that, the slot under a round-robin pointer.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is empty, the round-robin pointer is at slot 0, and respValid, respHit, respDirty and respPaddr are all 0.
- R2: A lookup hits only when some slot is valid and its stored tag equals lookupVpn. On a hit, respPaddr is the stored physical page number in bits 23:12, with lookupOffset unchanged in bits 11:0.
- R3: A lookup that misses, including one whose tag matches a slot with valid 0, gives respHit 0, respDirty 0 and respPaddr 0.
- R4: respValid is 1 in exactly the cycle after a cycle with lookupValid 1. All lookup results are registered and appear in that same cycle.
- R5: A lookup with lookupWrite 1 that hits sets that slot's dirty flag. Every hit reports the slot's dirty flag after the access, so a write hit always reports 1.
- R6: A fill whose fillVpn equals the tag of a valid slot overwrites that slot's physical page number, so no two valid slots ever share a tag.
- R7: Otherwise a fill writes the lowest-numbered slot whose valid flag is 0.
- R8: When every slot is valid and no tag matches, a fill writes the slot under the round-robin pointer. The pointer moves up by one on every accepted fill and wraps from ENTRIES-1 to 0.
- R9: A filled slot becomes valid with its dirty flag cleared.
- R10: flush clears every valid flag in one cycle. A fill in the same cycle is ignored and does not move the pointer.
- R11: A lookup in the same cycle as a fill, flush or dirty update sees the slot contents as they were before that cycle's update.
- R12: A write lookup that misses changes no slot and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupWrite | input | 1 | Lookup is for a store; sets dirty on hit |
| lookupVpn | input | 20 | Virtual page number to translate |
| lookupOffset | input | 12 | Page offset passed through to the result |
| fillValid | input | 1 | Write a translation this cycle |
| fillVpn | input | 20 | Virtual page tag to install |
| fillPpn | input | 12 | Physical page number to install |
| flush | input | 1 | Invalidate all slots |
| respValid | output | 1 | Lookup result present |
| respHit | output | 1 | Lookup matched a valid slot |
| respDirty | output | 1 | Dirty flag of the matched slot |
| respPaddr | output | 24 | Physical address on hit, 0 on miss |

## Verification
The assertions assume that reset is applied before the first request and that tag uniqueness is reached only through the fill port. The one-match check relies on that, because it holds only when every fill goes through the victim choice. The stimulus drives inputs away from the clock edge and draws its tags from a small fixed pool. This forces refills of present tags, replacement when the cache is full, and lookups of tags that were flushed. Flush, fill and lookup are also placed in the same cycle, so the ordering rules come under the checks.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VPN_W = 20;
  localparam int PPN_W = 12;
  localparam int OFF_W = 12;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = 8;  // wide enough for the 256-slot maximum

  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             dirtyEn;
    logic [IDX_W-1:0] dirtyIdx;
    logic             flushAll;
  } xlateStrobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic               fillValid,
  input  logic               flush,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] lookupHitVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  output xlateStrobe_t       strobe
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptrQ;

  // lowest set bit wins
  function automatic logic [IDX_W-1:0] firstSet(input logic [ENTRIES-1:0] v);
    firstSet = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) firstSet = IDX_W'(i);
    end
  endfunction

  always_comb begin
    strobe.flushAll = flush;
    strobe.fillEn   = fillValid && !flush;
    if (|fillHitVec)      strobe.fillIdx = firstSet(fillHitVec);
    else if (~&validVec)  strobe.fillIdx = firstSet(~validVec);
    else                  strobe.fillIdx = IDX_W'(ptrQ);
    strobe.dirtyEn  = lookupValid && lookupWrite && (|lookupHitVec);
    strobe.dirtyIdx = firstSet(lookupHitVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.fillEn) begin
      ptrQ <= (ptrQ == PTR_LAST) ? '0 : ptrQ + PTR_W'(1);
    end
  end

  // R8: pointer steps by one per accepted fill, wrapping at the last slot
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> ptrQ == (($past(ptrQ) == PTR_LAST) ? '0 : $past(ptrQ) + PTR_W'(1)));

  // R10: a fill during flush leaves the pointer alone
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && flush) |=> $stable(ptrQ));
endmodule

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [OFF_W-1:0]   lookupOffset,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  xlateStrobe_t       strobe,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] lookupHitVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic               respValid,
  output logic               respHit,
  output logic               respDirty,
  output logic [PA_W-1:0]    respPaddr
);
  logic [ENTRIES-1:0] dirtyVec;
  logic [ENTRIES-1:0] fillSelVec;
  logic [ENTRIES-1:0] dirtySelVec;
  logic [PPN_W-1:0]   ppnArr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic             slotValidQ;
    logic             slotDirtyQ;
    logic [VPN_W-1:0] slotVpnQ;
    logic [PPN_W-1:0] slotPpnQ;

    assign fillSelVec[g]  = strobe.fillEn && (strobe.fillIdx == IDX_W'(g));
    assign dirtySelVec[g] = strobe.dirtyEn && (strobe.dirtyIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValidQ <= 1'b0;
        slotDirtyQ <= 1'b0;
      end else begin
        if (strobe.flushAll)   slotValidQ <= 1'b0;
        else if (fillSelVec[g]) slotValidQ <= 1'b1;
        if (fillSelVec[g])       slotDirtyQ <= 1'b0;
        else if (dirtySelVec[g]) slotDirtyQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillSelVec[g]) begin
        slotVpnQ <= fillVpn;
        slotPpnQ <= fillPpn;
      end
    end

    assign validVec[g]     = slotValidQ;
    assign dirtyVec[g]     = slotDirtyQ;
    assign ppnArr[g]       = slotPpnQ;
    assign lookupHitVec[g] = slotValidQ && (slotVpnQ == lookupVpn);
    assign fillHitVec[g]   = slotValidQ && (slotVpnQ == fillVpn);
  end

  logic             anyHit;
  logic [PPN_W-1:0] ppnSel;
  logic             dirtySel;

  always_comb begin
    ppnSel   = '0;
    dirtySel = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupHitVec[i]) begin
        ppnSel   = ppnSel | ppnArr[i];
        dirtySel = dirtySel | dirtyVec[i];
      end
    end
    anyHit = |lookupHitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respDirty <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && anyHit;
      respDirty <= lookupValid && anyHit && (dirtySel || lookupWrite);
      respPaddr <= (lookupValid && anyHit) ? {ppnSel, lookupOffset} : '0;
    end
  end

  // R6: fills never create a second valid copy of a tag
  a_r6_one_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupHitVec));

  // R4: response valid follows request by one cycle
  a_r4_resp_on: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);
  a_r4_resp_off: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R10: flush empties every slot
  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> validVec == '0);

  // R9: the filled slot is valid and clean
  a_r9_fill_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> (|(validVec & $past(fillSelVec))) && !(|(dirtyVec & $past(fillSelVec))));

  // R5: a write hit leaves its slot dirty unless a fill took the slot
  a_r5_dirty_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dirtyEn && !(|(fillSelVec & dirtySelVec))) |=> |(dirtyVec & $past(dirtySelVec)));

  // R3: a miss carries no address and no dirty flag
  a_r3_miss_clean: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respPaddr == '0 && !respDirty));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic [19:0]      lookupVpn,
  input  logic [11:0]      lookupOffset,
  input  logic             fillValid,
  input  logic [19:0]      fillVpn,
  input  logic [11:0]      fillPpn,
  input  logic             flush,
  output logic             respValid,
  output logic             respHit,
  output logic             respDirty,
  output logic [23:0]      respPaddr
);
  xlateStrobe_t       strobe;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] lookupHitVec;
  logic [ENTRIES-1:0] fillHitVec;

  xlate_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .lookupWrite  (lookupWrite),
    .fillValid    (fillValid),
    .flush        (flush),
    .validVec     (validVec),
    .lookupHitVec (lookupHitVec),
    .fillHitVec   (fillHitVec),
    .strobe       (strobe)
  );

  xlate_store #(.ENTRIES(ENTRIES)) uStore (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .lookupWrite  (lookupWrite),
    .lookupVpn    (lookupVpn),
    .lookupOffset (lookupOffset),
    .fillVpn      (fillVpn),
    .fillPpn      (fillPpn),
    .strobe       (strobe),
    .validVec     (validVec),
    .lookupHitVec (lookupHitVec),
    .fillHitVec   (fillHitVec),
    .respValid    (respValid),
    .respHit      (respHit),
    .respDirty    (respDirty),
    .respPaddr    (respPaddr)
  );
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  localparam int N = 8;
  localparam int POOL = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic [11:0] lookupOffset = '0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [11:0] fillPpn = '0;
  logic        flush = 1'b0;
  logic        respValid, respHit, respDirty;
  logic [23:0] respPaddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the slots
  bit          mV [N];
  bit          mD [N];
  logic [19:0] mVpn [N];
  logic [11:0] mPpn [N];
  int          mPtr = 0;
  logic [19:0] pool [POOL];
  int unsigned lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  xlate_cache #(.ENTRIES(N)) uut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVpn(lookupVpn), .lookupOffset(lookupOffset),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .flush(flush),
    .respValid(respValid), .respHit(respHit),
    .respDirty(respDirty), .respPaddr(respPaddr)
  );

  function automatic int unsigned nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  task automatic check(input string tag, input logic v, h, d, input logic [23:0] pa,
                       input logic ev, eh, ed, input logic [23:0] epa);
    checks++;
    if (v !== ev || h !== eh || d !== ed || pa !== epa) begin
      errors++;
      $display("FAIL %s: got valid=%b hit=%b dirty=%b paddr=%h, expected valid=%b hit=%b dirty=%b paddr=%h",
               tag, v, h, d, pa, ev, eh, ed, epa);
    end
  endtask

  // one clock of stimulus; called at a falling edge, returns at the next one
  task automatic doCycle(input logic lv, input logic lw, input logic [19:0] lvpn,
                         input logic [11:0] loff, input logic fv, input logic [19:0] fvpn,
                         input logic [11:0] fppn, input logic fl, input string tag);
    logic eh, ed;
    logic [23:0] epa;
    int hitIdx, victim;
    eh = 1'b0; ed = 1'b0; epa = '0; hitIdx = -1;
    for (int i = 0; i < N; i++) begin
      if (mV[i] && mVpn[i] == lvpn) begin
        eh = lv; hitIdx = i;
        ed = lv && (mD[i] || lw);
        epa = lv ? {mPpn[i], loff} : 24'h0;
      end
    end
    lookupValid = lv; lookupWrite = lw; lookupVpn = lvpn; lookupOffset = loff;
    fillValid = fv; fillVpn = fvpn; fillPpn = fppn; flush = fl;
    @(negedge clk);
    check(tag, respValid, respHit, respDirty, respPaddr, lv, eh, ed, epa);
    lookupValid = 1'b0; lookupWrite = 1'b0; fillValid = 1'b0; flush = 1'b0;
    // model update: dirty, then fill over it, then flush
    if (lv && lw && hitIdx >= 0) mD[hitIdx] = 1'b1;
    if (fv && !fl) begin
      victim = -1;
      for (int i = 0; i < N; i++) if (victim < 0 && mV[i] && mVpn[i] == fvpn) victim = i;
      for (int i = 0; i < N; i++) if (victim < 0 && !mV[i]) victim = i;
      if (victim < 0) victim = mPtr;
      mV[victim] = 1'b1; mD[victim] = 1'b0;
      mVpn[victim] = fvpn; mPpn[victim] = fppn;
      mPtr = (mPtr + 1) % N;
    end
    if (fl) for (int i = 0; i < N; i++) mV[i] = 1'b0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input string tag);
    doCycle(1'b1, 1'b0, vpn, off, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [11:0] ppn, input string tag);
    doCycle(1'b0, 1'b0, '0, '0, 1'b1, vpn, ppn, 1'b0, tag);
  endtask

  task automatic sweepPool(input string tag);
    for (int k = 0; k < POOL; k++) look(pool[k], 12'(k * 171), tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got no finish, expected completion");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < POOL; k++) pool[k] = 20'h01A00 + 20'(k * 4099);
    for (int i = 0; i < N; i++) begin mV[i] = 0; mD[i] = 0; mVpn[i] = '0; mPpn[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    check("R1 reset", respValid, respHit, respDirty, respPaddr, 1'b0, 1'b0, 1'b0, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    look(pool[0], 12'h123, "R1 empty after reset");
    doCycle(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "R4 idle");

    // R7, R11: fill empty slots, looking up the same tag in the fill cycle
    for (int k = 0; k < N; k++)
      doCycle(1'b1, 1'b0, pool[k], 12'h0AB, 1'b1, pool[k], 12'(12'hF00 ^ (k * 5)), 1'b0, "R11 lookup during fill");
    // R2: every slot with several offsets
    for (int k = 0; k < N; k++) begin
      look(pool[k], 12'h000, "R2 hit offset low");
      look(pool[k], 12'hFFF, "R2 hit offset high");
      look(pool[k], 12'(k * 311), "R2 hit offset mid");
    end
    // R3: absent tags, one bit off a present tag
    look(pool[0] ^ 20'h00001, 12'h777, "R3 miss near tag");
    look(pool[N], 12'h777, "R3 miss absent tag");
    // R5: write hits then reads
    doCycle(1'b1, 1'b1, pool[2], 12'h010, 1'b0, '0, '0, 1'b0, "R5 write hit");
    doCycle(1'b1, 1'b1, pool[5], 12'h020, 1'b0, '0, '0, 1'b0, "R5 write hit");
    for (int k = 0; k < N; k++) look(pool[k], 12'h555, "R5 dirty readback");
    // R12: write miss changes nothing
    doCycle(1'b1, 1'b1, pool[N + 1], 12'h030, 1'b0, '0, '0, 1'b0, "R12 write miss");
    sweepPool("R12 no allocation");
    // R6: refill a present tag with a new frame; dirty cleared per R9
    fill(pool[2], 12'hABC, "R6 refill");
    look(pool[2], 12'h444, "R6 new frame, R9 clean");
    sweepPool("R6 other slots kept");
    // R8: replacement when full
    for (int k = N; k < POOL; k++) begin
      fill(pool[k], 12'(k * 97), "R8 replace");
      sweepPool("R8 after replace");
    end
    // R10, R11: flush with fill and lookup in the same cycle
    doCycle(1'b1, 1'b0, pool[POOL - 1], 12'h321, 1'b1, pool[0], 12'h111, 1'b1, "R11 lookup during flush");
    sweepPool("R10 all empty after flush");
    // R3: tag still stored but slot invalid
    look(pool[POOL - 1], 12'h001, "R3 stale tag misses");
    // mixed traffic over the pool
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = nextRand();
      doCycle(r[0], r[1], pool[(r >> 4) % POOL], 12'(r >> 9), r[2] && r[3],
              pool[(r >> 12) % POOL], 12'(r >> 17), (r[7:2] == 6'd0), "R2 R5 R8 mixed");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule